// File: doc/BRIEF.md
# Streaming SPI Master with Programmable Timing

This block is an SPI master for one slave. Bytes to send come in through a valid/ready stream. Each byte is shifted out on MOSI with the most significant bit first. At the same time a byte is shifted in from MISO, and that byte leaves through a second valid/ready stream. A small register file sets five things: the SCLK idle level, the sampling phase, the setup time from chip select to the first clock edge, the hold time from the last clock edge to chip select release, and the SCLK half period. All times are counted in system clocks. The settings in force are captured when a transfer starts. Writes made while a transfer is running therefore apply to the next transfer.

The control sits in one state machine. **IDLE** keeps chip select high and SCLK at the programmed idle level. A byte taken from the input stream moves it to **SETUP**, where chip select is low and the setup delay counts down. When the setup delay has run out, the first SCLK edge is produced and the machine enters **SHIFT**. **SHIFT** toggles SCLK once per half period until sixteen edges have been made. At the sixteenth edge there are three exits. If another byte is waiting and the output holding register can take the finished byte, the machine stays in **SHIFT** and the burst continues. If no byte is waiting, it moves to **HOLD**. If the output register is still occupied, it moves to **DRAIN**. **DRAIN** keeps chip select low until the finished byte can be handed over, then moves to **HOLD**. **HOLD** counts the hold delay, raises chip select and returns to **IDLE**.

Top module: `spi_stream_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, rx_valid is 0 and tx_ready is 1.
- R2: A write with cfg_wr high stores cfg_wdata in a register chosen by cfg_addr. Address 0 holds the idle SCLK level in bit 0. Address 1 holds the phase in bit 0. Address 2 holds the setup delay, address 3 the hold delay and address 4 the half period.
- R3: While spi_cs_n is high, spi_sclk equals the stored idle level. After the sixteenth edge of a byte, spi_sclk is back at that level.
- R4: With phase 0, MOSI shows a bit before the first edge of that bit, and MISO is sampled on odd edges. With phase 1, MISO is sampled on even edges. Every byte takes 16 SCLK edges and is sent MSB first.
- R5: The first SCLK edge comes exactly max(setup,1) system clocks after spi_cs_n falls.
- R6: Consecutive SCLK edges are max(half,1) system clocks apart. This also holds between bytes of a burst.
- R7: spi_cs_n rises exactly max(hold,1) system clocks after the last SCLK edge when the output register is free. No SCLK edge coincides with that rise.
- R8: Every accepted input byte yields exactly one output byte, equal to the byte the slave shifted out during that transfer.
- R9: If a new input byte is valid at the sixteenth edge and the output register is free, spi_cs_n stays low and the new byte follows with no gap.
- R10: While rx_valid is high and rx_ready is low, rx_valid and rx_data stay unchanged. A finished byte is never dropped, and chip select stays low until it has been handed over. tx_ready is high only when the output register is empty or being emptied.
- R11: Settings written during a transfer do not change that transfer's timing. They apply from the next transfer onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (0..4) |
| cfg_wdata | input | REG_W | Register write data |
| tx_valid | input | 1 | Input byte valid |
| tx_ready | output | 1 | Input byte accepted this cycle when valid |
| tx_data | input | 8 | Byte to shift out |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The timing results are measured in system clocks from the edge that causes each event. spi_cs_n falls on the same edge that completes the input handshake. The first SCLK toggle follows max(setup,1) clocks later. Each later toggle follows max(half,1) clocks after the one before it. spi_cs_n rises max(hold,1) clocks after the last toggle, and rx_valid rises on the edge of the sixteenth toggle. The bench counts clock edges and samples every output at the falling clock edge, so each measured difference is taken in the exact cycle the result becomes visible. Its slave model uses the MOSI value seen one falling edge earlier, so it never races a bit change on the same edge.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

    localparam int BYTE_W         = 8;
    localparam int EDGES_PER_BYTE = 2 * BYTE_W;
    localparam int EDGE_W         = $clog2(EDGES_PER_BYTE + 1);

    localparam logic [2:0] ADDR_IDLE_LVL = 3'd0;
    localparam logic [2:0] ADDR_PHASE    = 3'd1;
    localparam logic [2:0] ADDR_SETUP    = 3'd2;
    localparam logic [2:0] ADDR_HOLD     = 3'd3;
    localparam logic [2:0] ADDR_HALF     = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_DRAIN,
        ST_HOLD
    } spi_state_e;

endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_stream_pkg::*;
#(
    parameter int DLY_W  = 8,
    parameter int HALF_W = 8,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic              idle_lvl,
    output logic              phase,
    output logic [DLY_W-1:0]  setup_dly,
    output logic [DLY_W-1:0]  hold_dly,
    output logic [HALF_W-1:0] half_len
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_lvl  <= 1'b0;
            phase     <= 1'b0;
            setup_dly <= '0;
            hold_dly  <= '0;
            half_len  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_IDLE_LVL: idle_lvl  <= wdata[0];
                ADDR_PHASE:    phase     <= wdata[0];
                ADDR_SETUP:    setup_dly <= wdata[DLY_W-1:0];
                ADDR_HOLD:     hold_dly  <= wdata[DLY_W-1:0];
                ADDR_HALF:     half_len  <= wdata[HALF_W-1:0];
                default:       ;
            endcase
        end
    end

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold
    import spi_stream_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    output logic              free,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data
);

    assign free = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (push) begin
            out_valid <= 1'b1;
            out_data  <= push_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_stream_pkg::*;
#(
    parameter int DLY_W  = 8,
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_idle_lvl,
    input  logic              cfg_phase,
    input  logic [DLY_W-1:0]  cfg_setup,
    input  logic [DLY_W-1:0]  cfg_hold,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_free,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES_PER_BYTE);

    spi_state_e state_q, state_d;

    logic              phase_s;
    logic [DLY_W-1:0]  setup_s, hold_s, cnt_q;
    logic [HALF_W-1:0] half_s, hc_q;
    logic [EDGE_W-1:0] edge_q;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic              sclk_q, cs_n_q;

    logic [DLY_W-1:0]  setup_eff, hold_eff;
    logic [HALF_W-1:0] half_eff;
    logic [EDGE_W-1:0] edge_k;
    logic              edge_fire, is_sample, is_shift, byte_end, accept;
    logic [BYTE_W-1:0] rx_next;

    // Effective values: zero counts as one clock
    assign setup_eff = (setup_s == '0) ? DLY_W'(1)  : setup_s;
    assign hold_eff  = (hold_s  == '0) ? DLY_W'(1)  : hold_s;
    assign half_eff  = (half_s  == '0) ? HALF_W'(1) : half_s;

    assign edge_fire = ((state_q == ST_SETUP) && (cnt_q >= setup_eff)) ||
                       ((state_q == ST_SHIFT) && (hc_q >= half_eff - HALF_W'(1)));
    assign edge_k    = edge_q + EDGE_W'(1);
    assign is_sample = edge_k[0] ^ phase_s;
    assign is_shift  = !is_sample && (edge_k != EDGE_W'(1)) && (edge_k != LAST_EDGE);
    assign byte_end  = edge_fire && (edge_k == LAST_EDGE);
    assign rx_next   = is_sample ? {rx_sh[BYTE_W-2:0], miso} : rx_sh;

    assign tx_ready  = rx_free && ((state_q == ST_IDLE) || byte_end);
    assign accept    = tx_valid && tx_ready;
    assign rx_push   = rx_free && (byte_end || (state_q == ST_DRAIN));
    assign rx_byte   = (state_q == ST_DRAIN) ? rx_sh : rx_next;

    assign sclk = sclk_q;
    assign cs_n = cs_n_q;
    assign mosi = tx_sh[BYTE_W-1];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)    state_d = ST_SETUP;
            ST_SETUP: if (edge_fire) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (byte_end) begin
                    if (accept)       state_d = ST_SHIFT;
                    else if (rx_free) state_d = ST_HOLD;
                    else              state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: if (rx_free)   state_d = ST_HOLD;
            ST_HOLD:  if (cnt_q >= hold_eff) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_s <= 1'b0;
            setup_s <= '0;
            hold_s  <= '0;
            half_s  <= '0;
            cnt_q   <= '0;
            hc_q    <= '0;
            edge_q  <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sclk_q <= cfg_idle_lvl;
                    cs_n_q <= 1'b1;
                    if (accept) begin
                        phase_s <= cfg_phase;
                        setup_s <= cfg_setup;
                        hold_s  <= cfg_hold;
                        half_s  <= cfg_half;
                        tx_sh   <= tx_data;
                        cs_n_q  <= 1'b0;
                        cnt_q   <= DLY_W'(1);
                        edge_q  <= '0;
                    end
                end
                ST_SETUP, ST_SHIFT: begin
                    if (edge_fire) begin
                        sclk_q <= ~sclk_q;
                        hc_q   <= '0;
                        rx_sh  <= rx_next;
                        if (byte_end) begin
                            edge_q <= '0;
                            if (accept) tx_sh <= tx_data;
                            else        cnt_q <= DLY_W'(1);
                        end else begin
                            edge_q <= edge_k;
                            if (is_shift) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                    end else if (state_q == ST_SETUP) begin
                        cnt_q <= cnt_q + DLY_W'(1);
                    end else begin
                        hc_q <= hc_q + HALF_W'(1);
                    end
                end
                ST_DRAIN: begin
                    if (cnt_q < hold_eff) cnt_q <= cnt_q + DLY_W'(1);
                end
                ST_HOLD: begin
                    if (cnt_q >= hold_eff) cs_n_q <= 1'b1;
                    else                   cnt_q  <= cnt_q + DLY_W'(1);
                end
                default: cs_n_q <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master
    import spi_stream_pkg::*;
#(
    parameter  int DLY_W  = 8,
    parameter  int HALF_W = 8,
    localparam int REG_W  = (DLY_W > HALF_W) ? DLY_W : HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic              cfg_cpol, cfg_cpha;
    logic [DLY_W-1:0]  cfg_setup, cfg_hold;
    logic [HALF_W-1:0] cfg_half;
    logic              rx_free, rx_push;
    logic [BYTE_W-1:0] rx_byte;

    spi_cfg_regs #(.DLY_W(DLY_W), .HALF_W(HALF_W), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .idle_lvl  (cfg_cpol),
        .phase     (cfg_cpha),
        .setup_dly (cfg_setup),
        .hold_dly  (cfg_hold),
        .half_len  (cfg_half)
    );

    spi_shift_engine #(.DLY_W(DLY_W), .HALF_W(HALF_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_idle_lvl (cfg_cpol),
        .cfg_phase    (cfg_cpha),
        .cfg_setup    (cfg_setup),
        .cfg_hold     (cfg_hold),
        .cfg_half     (cfg_half),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_ready     (tx_ready),
        .rx_free      (rx_free),
        .rx_push      (rx_push),
        .rx_byte      (rx_byte),
        .sclk         (spi_sclk),
        .cs_n         (spi_cs_n),
        .mosi         (spi_mosi),
        .miso         (spi_miso)
    );

    spi_rx_hold u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_byte),
        .free      (rx_free),
        .out_valid (rx_valid),
        .out_ready (rx_ready),
        .out_data  (rx_data)
    );

endmodule

// File: rtl/spi_stream_master_chk.sv
module spi_stream_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       cfg_cpol,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       rx_push
);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (sclk == $past(cfg_cpol)));

    // R7
    no_edge_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $stable(sclk));

    // R9
    select_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !cs_n);

    // R10
    rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R10
    no_rx_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (!rx_valid || rx_ready));

    // R10
    accept_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!rx_valid || rx_ready));

endmodule

bind spi_stream_master spi_stream_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (spi_cs_n),
    .sclk     (spi_sclk),
    .cfg_cpol (cfg_cpol),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .rx_push  (rx_push)
);

// File: tb/spi_stream_master_tb.sv
module spi_stream_master_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = '0;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic [7:0] rx_data;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int vecs = 0;
    int errs = 0;
    int cyc  = 0;

    bit tb_cpol = 1'b0, tb_cpha = 1'b0, rx_hold = 1'b0;

    logic [7:0] tx_log[64], slv_got[64], slv_sent[64], rx_got[64];
    int n_tx = 0, n_slv = 0, n_rx = 0;

    int fall_cyc = 0, last_edge = 0, n_edges = 0, first_gap = 0;
    int min_sp = 0, max_sp = 0, post_gap = 0, cs_falls = 0;

    always #10 clk = ~clk;

    spi_stream_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Timing monitor
    logic m_cs = 1'b1, m_sclk = 1'b0;
    always @(negedge clk) begin
        if (m_cs && !spi_cs_n) begin
            fall_cyc = cyc; n_edges = 0; cs_falls++;
            min_sp = 1000000; max_sp = 0;
        end
        if (!spi_cs_n && spi_sclk != m_sclk) begin
            if (n_edges == 0) first_gap = cyc - fall_cyc;
            else begin
                if (cyc - last_edge < min_sp) min_sp = cyc - last_edge;
                if (cyc - last_edge > max_sp) max_sp = cyc - last_edge;
            end
            last_edge = cyc; n_edges++;
        end
        if (!m_cs && spi_cs_n) post_gap = cyc - last_edge;
        m_cs = spi_cs_n; m_sclk = spi_sclk;
    end

    // SPI slave model
    logic s_cs = 1'b1, s_sclk = 1'b0, s_mosi = 1'b0, s_lead;
    logic [7:0] s_tx = '0, s_rx = '0;
    int s_bits = 0, s_loads = 0;
    always @(negedge clk) begin
        if (!spi_cs_n && s_cs) begin
            s_bits = 0;
            if (!tb_cpha) begin
                s_tx = 8'h5A + 8'(s_loads * 29); s_loads++;
                spi_miso = s_tx[7];
            end
        end
        if (!spi_cs_n && spi_sclk != s_sclk) begin
            s_lead = (spi_sclk != tb_cpol);
            if (s_lead != tb_cpha) begin
                s_rx = {s_rx[6:0], s_mosi}; s_bits++;
                if (s_bits == 8) begin
                    slv_got[n_slv] = s_rx; slv_sent[n_slv] = s_tx;
                    n_slv++; s_bits = 0;
                end
            end else begin
                if (s_bits == 0) begin
                    s_tx = 8'h5A + 8'(s_loads * 29); s_loads++;
                end
                spi_miso = s_tx[7-s_bits];
            end
        end
        s_cs = spi_cs_n; s_sclk = spi_sclk; s_mosi = spi_mosi;
    end

    // Receive consumer
    always @(negedge clk) begin
        rx_ready = !rx_hold;
        if (rx_valid && rx_ready) begin
            rx_got[n_rx] = rx_data; n_rx++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic configure(input bit cp, input bit ph, input int pre, input int post, input int half);
        tb_cpol = cp; tb_cpha = ph;
        reg_write(3'd0, 8'(cp));
        reg_write(3'd1, 8'(ph));
        reg_write(3'd2, 8'(pre));
        reg_write(3'd3, 8'(post));
        reg_write(3'd4, 8'(half));
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bytes(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            tx_data = seed + 8'(i * 59); tx_valid = 1'b1;
            tx_log[n_tx] = tx_data; n_tx++;
            #1;
            while (!tx_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        tx_valid = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!spi_cs_n && guard < 5000) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_data(input string req, input int base_tx, input int base_slv,
                              input int base_rx, input int n);
        chk({req, " R8 rx count"}, n_rx - base_rx, n);
        for (int i = 0; i < n; i++) begin
            chk({req, " R4 slave saw byte"}, slv_got[base_slv+i], tx_log[base_tx+i]);
            chk({req, " R8 returned byte"}, rx_got[base_rx+i], slv_sent[base_slv+i]);
        end
    endtask

    task automatic run_xfer(input string tag, input bit cp, input bit ph, input int pre,
                            input int post, input int half, input int n, input logic [7:0] seed);
        int bt, bs, br, cf;
        configure(cp, ph, pre, post, half);
        chk({tag, " R3 idle level"}, spi_sclk, cp);
        bt = n_tx; bs = n_slv; br = n_rx; cf = cs_falls;
        send_bytes(n, seed);
        wait_done();
        chk({tag, " R9 single select"}, cs_falls - cf, 1);
        chk({tag, " R4 edge count"}, n_edges, 16 * n);
        chk({tag, " R5 setup delay"}, first_gap, (pre == 0) ? 1 : pre);
        chk({tag, " R6 min half"}, min_sp, (half == 0) ? 1 : half);
        chk({tag, " R6 max half"}, max_sp, (half == 0) ? 1 : half);
        chk({tag, " R7 hold delay"}, post_gap, (post == 0) ? 1 : post);
        chk({tag, " R3 idle after"}, spi_sclk, cp);
        check_data(tag, bt, bs, br, n);
    endtask

    task automatic test_reset();
        chk("R1 cs_n", spi_cs_n, 1);
        chk("R1 sclk", spi_sclk, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 tx_ready", tx_ready, 1);
    endtask

    task automatic test_backpressure();
        int bt, bs, br;
        logic [7:0] held;
        configure(1'b0, 1'b0, 1, 1, 1);
        rx_hold = 1'b1;
        bt = n_tx; bs = n_slv; br = n_rx;
        send_bytes(2, 8'h17);
        repeat (60) @(negedge clk);
        chk("R10 valid held", rx_valid, 1);
        chk("R10 cs kept low", spi_cs_n, 0);
        chk("R10 first byte held", rx_data, slv_sent[bs]);
        held = rx_data;
        repeat (10) @(negedge clk);
        chk("R10 data stable", rx_data, held);
        rx_hold = 1'b0;
        wait_done();
        check_data("R10", bt, bs, br, 2);
    endtask

    task automatic test_midwrite();
        configure(1'b0, 1'b1, 1, 1, 2);
        send_bytes(1, 8'hC6);
        reg_write(3'd4, 8'd4);
        wait_done();
        chk("R11 old half min", min_sp, 2);
        chk("R11 old half max", max_sp, 2);
        send_bytes(1, 8'h39);
        wait_done();
        chk("R11 R2 new half", min_sp, 4);
        chk("R11 R2 new half max", max_sp, 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_xfer("mode0 R2", 1'b0, 1'b0, 2, 3, 2, 1, 8'hA5);
        run_xfer("mode1 R2", 1'b0, 1'b1, 4, 1, 3, 1, 8'h3C);
        run_xfer("mode2 R2", 1'b1, 1'b0, 1, 2, 1, 1, 8'h81);
        run_xfer("mode3 R2", 1'b1, 1'b1, 3, 5, 2, 1, 8'h5E);
        run_xfer("burst R9", 1'b0, 1'b1, 2, 2, 2, 3, 8'h96);
        run_xfer("zero R5 R6 R7", 1'b1, 1'b0, 0, 0, 0, 2, 8'hE1);
        test_backpressure();
        test_midwrite();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule